// File: doc/BRIEF.md
# SFR page context stack

This block keeps the page selector for a banked special-function-register space, along with two saved copies of it. The three entries form a short stack. The top entry is the page the CPU uses right now. The second entry holds the page that was active before the current interrupt. The third entry holds the page from one nesting level further out. When an interrupt is serviced, the interrupting source's page goes on top and the older pages move down one place. When the return-from-interrupt instruction executes, the saved pages move back up.

Software can read and write every entry through a small register port. An interrupt handler can therefore change a saved page so that the return lands somewhere else. A scheduler can use this to switch task contexts. A control register holds an automatic-mode enable bit. While that bit is clear, the stack ignores interrupt entry and return completely. The interrupt controller, the CPU and the SFR address decoding are outside this block.

Top module: `sfr_page_stack`

## Requirements
- R1: While reset is held, and on the first clock after it, all three entries read 0x00 and the automatic-mode enable reads 1.
- R2: On an entry strobe with automatic mode enabled, the stack pushes at the next clock edge. The top entry takes `irq_page`, the second entry takes the old top, and the third entry takes the old second. The old third value is lost.
- R3: On a return strobe with automatic mode enabled, the stack pops at the next clock edge. The top entry takes the old second, the second takes the old third, and the third keeps its value.
- R4: With no push, no pop and no write, every entry holds its value. Changing `reg_sel` alone has no effect.
- R5: `reg_rdata` is combinational. Select 0 returns the top entry, 1 the second entry, 2 the third entry and 3 the control register.
- R6: A write (`reg_wr`=1) with select 0, 1 or 2 loads `reg_wdata` into that entry at the next edge. This also works while automatic mode is disabled.
- R7: If an entry write happens in the same cycle as a push or pop, the push or pop takes effect and the write is dropped.
- R8: While the enable bit is 0, entry and return strobes have no effect on any entry.
- R9: Bit 0 of the control register is the enable bit. A write with select 3 loads `reg_wdata[0]` into it. The other control bits always read 0. A push or pop in the same cycle as a control write is decided by the enable value from before that write.
- R10: If the entry strobe and the return strobe are both asserted in one cycle, only the push happens.
- R11: If software writes a new value into the second entry while an interrupt is being serviced, the following return makes that value the active page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_enter | input | 1 | Interrupt-service strobe (push request) |
| irq_page | input | PAGE_W | Page belonging to the interrupting source |
| irq_return | input | 1 | Return-from-interrupt strobe (pop request) |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | SEL_W | Register select: 0 top, 1 second, 2 third, 3 control |
| reg_wdata | input | PAGE_W | Register write data |
| reg_rdata | output | PAGE_W | Register read data for `reg_sel` |
| page_o | output | PAGE_W | Active page (top entry) |
| auto_en_o | output | 1 | Automatic-mode enable bit |

## Verification
The properties assume that every input is at a defined level on each rising edge once reset has been released. They make no assumption about how strobes or writes line up with each other, because the design resolves every combination by a fixed priority. The bench changes all inputs on the falling edge only, and it starts from an idle pattern with every strobe low. It then drives the coincident cases on purpose: a write during a push, a write during a pop, a control write during a push, and both strobes together. Each of these is tested rather than avoided.

// File: rtl/sfr_stack_pkg.sv
package sfr_stack_pkg;

  // Kind of stack movement decided for one cycle
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;

  // Position of the automatic-mode enable within the control register
  localparam int CTL_EN_BIT = 0;

  // Entry has priority over return; nothing moves while disabled
  function automatic stk_op_e pick_op(input logic en, input logic enter,
                                      input logic ret);
    stk_op_e op;
    op = OP_HOLD;
    if (en) begin
      if (enter)    op = OP_PUSH;
      else if (ret) op = OP_POP;
    end
    return op;
  endfunction

  // True when a select value addresses stack entry idx
  function automatic logic sel_hits(input int sel, input int idx);
    return sel == idx;
  endfunction

endpackage

// File: rtl/sfr_stack_ctrl.sv
module sfr_stack_ctrl
  import sfr_stack_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_enter,
  input  logic              irq_return,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic              auto_en,
  output logic              push_ev,
  output logic              pop_ev,
  output logic [DEPTH-1:0]  wr_hit
);

  logic    en_q;
  logic    ctl_wr;
  stk_op_e op;

  assign ctl_wr = reg_wr && sel_hits(int'(reg_sel), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b1;
    else if (ctl_wr) en_q <= reg_wdata[CTL_EN_BIT];
  end

  assign auto_en = en_q;
  assign op      = pick_op(en_q, irq_enter, irq_return);
  assign push_ev = (op == OP_PUSH);
  assign pop_ev  = (op == OP_POP);

  // A software write to an entry only lands in a cycle without movement
  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign wr_hit[i] = reg_wr && sel_hits(int'(reg_sel), i) && (op == OP_HOLD);
  end

endmodule

// File: rtl/sfr_stack_entries.sv
module sfr_stack_entries #(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_ev,
  input  logic                          pop_ev,
  input  logic [DEPTH-1:0]              wr_hit,
  input  logic [PAGE_W-1:0]             wdata,
  input  logic [PAGE_W-1:0]             enter_page,
  output logic [DEPTH-1:0][PAGE_W-1:0]  stk_q
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [PAGE_W-1:0] ent_q;
    logic [PAGE_W-1:0] from_above;
    logic [PAGE_W-1:0] from_below;

    // Value shifted in on a push
    if (i == 0) begin : g_top
      assign from_above = enter_page;
    end else begin : g_mid
      assign from_above = stk_q[i-1];
    end

    // Value shifted in on a pop; the deepest entry keeps its own
    if (i == DEPTH - 1) begin : g_bot
      assign from_below = ent_q;
    end else begin : g_up
      assign from_below = stk_q[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ent_q <= '0;
      else if (push_ev)   ent_q <= from_above;
      else if (pop_ev)    ent_q <= from_below;
      else if (wr_hit[i]) ent_q <= wdata;
    end

    assign stk_q[i] = ent_q;
  end

endmodule

// File: rtl/sfr_stack_rdport.sv
module sfr_stack_rdport
  import sfr_stack_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3,
  parameter int SEL_W  = 2
) (
  input  logic [DEPTH-1:0][PAGE_W-1:0] stk_q,
  input  logic                         auto_en,
  input  logic [SEL_W-1:0]             reg_sel,
  output logic [PAGE_W-1:0]            rdata
);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel_hits(int'(reg_sel), i)) rdata = stk_q[i];
    end
    if (sel_hits(int'(reg_sel), DEPTH)) rdata[CTL_EN_BIT] = auto_en;
  end

endmodule

// File: rtl/sfr_page_stack.sv
module sfr_page_stack #(
  parameter  int PAGE_W = 8,
  parameter  int DEPTH  = 3,
  localparam int SEL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_enter,
  input  logic [PAGE_W-1:0] irq_page,
  input  logic              irq_return,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  output logic [PAGE_W-1:0] page_o,
  output logic              auto_en_o
);

  // Named internal events, visible to the bound checker
  logic                        push_ev;
  logic                        pop_ev;
  logic [DEPTH-1:0]            wr_hit;
  logic [DEPTH-1:0][PAGE_W-1:0] stk_q;
  logic                        auto_en;

  sfr_stack_ctrl #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .auto_en    (auto_en),
    .push_ev    (push_ev),
    .pop_ev     (pop_ev),
    .wr_hit     (wr_hit)
  );

  sfr_stack_entries #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_entries (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_ev    (push_ev),
    .pop_ev     (pop_ev),
    .wr_hit     (wr_hit),
    .wdata      (reg_wdata),
    .enter_page (irq_page),
    .stk_q      (stk_q)
  );

  sfr_stack_rdport #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_rd (
    .stk_q   (stk_q),
    .auto_en (auto_en),
    .reg_sel (reg_sel),
    .rdata   (reg_rdata)
  );

  assign page_o    = stk_q[0];
  assign auto_en_o = auto_en;

endmodule

// File: rtl/sfr_stack_chk.sv
module sfr_stack_chk #(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3,
  parameter int SEL_W  = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [PAGE_W-1:0]            irq_page,
  input logic                         reg_wr,
  input logic [SEL_W-1:0]             reg_sel,
  input logic [PAGE_W-1:0]            reg_rdata,
  input logic [PAGE_W-1:0]            page_o,
  input logic                         auto_en_o,
  input logic                         push_ev,
  input logic                         pop_ev,
  input logic [DEPTH-1:0][PAGE_W-1:0] stk_q
);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (stk_q == '0 && auto_en_o));

  p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> page_o == $past(irq_page));

  p_push_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> stk_q[1] == $past(stk_q[0]));

  p_pop_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |=> (stk_q[0] == $past(stk_q[1]) &&
                stk_q[DEPTH-1] == $past(stk_q[DEPTH-1])));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ev && !pop_ev && !reg_wr) |=> $stable(stk_q));

  p_read_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == '0) |-> reg_rdata == page_o);

  p_write_loses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ev && reg_wr) |=> page_o == $past(stk_q[1]));

  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en_o |-> (!push_ev && !pop_ev));

  p_one_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_ev, pop_ev}));

endmodule

bind sfr_page_stack sfr_stack_chk #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_page  (irq_page),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata),
  .page_o    (page_o),
  .auto_en_o (auto_en_o),
  .push_ev   (push_ev),
  .pop_ev    (pop_ev),
  .stk_q     (stk_q)
);

// File: tb/tb_sfr_page_stack.sv
module tb_sfr_page_stack;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_enter = 1'b0;
  logic [7:0] irq_page = '0;
  logic       irq_return = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] page_o;
  logic       auto_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model: q[0] is the active page, deeper pages follow
  logic [7:0] q[$];
  bit         m_en;

  always #5 clk = ~clk;

  sfr_page_stack dut (
    .clk(clk), .rst_n(rst_n), .irq_enter(irq_enter), .irq_page(irq_page),
    .irq_return(irq_return), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_o(page_o),
    .auto_en_o(auto_en_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Advance the model by one edge using the inputs in force at that edge
  task automatic model_step();
    bit en_before = m_en;
    if (en_before && irq_enter) begin
      q.push_front(irq_page);
      void'(q.pop_back());
    end else if (en_before && irq_return) begin
      logic [7:0] deep = q[$];
      void'(q.pop_front());
      q.push_back(deep);
    end else if (reg_wr && reg_sel < 2'd3) begin
      q[reg_sel] = reg_wdata;
    end
    if (reg_wr && reg_sel == 2'd3) m_en = reg_wdata[0];
  endtask

  // One cycle: drive after a falling edge, model at rising edge, compare at next falling edge
  task automatic cyc(input bit ent, input bit ret, input bit wr, input logic [1:0] sel,
                     input logic [7:0] wd, input logic [7:0] pg, input string req);
    irq_enter = ent; irq_return = ret; reg_wr = wr; reg_sel = sel;
    reg_wdata = wd; irq_page = pg;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(req, page_o, q[0]);
    check(req, {7'd0, auto_en_o}, {7'd0, m_en});
  endtask

  // Read every register through the port without an edge in between
  task automatic peek(input string req);
    irq_enter = 0; irq_return = 0; reg_wr = 0;
    for (int s = 0; s < 4; s++) begin
      reg_sel = 2'(s);
      #1;
      if (s < 3) check({req, " R5"}, reg_rdata, q[s]);
      else       check({req, " R5 R9"}, reg_rdata, {7'd0, m_en});
    end
  endtask

  initial begin
    q = '{8'h00, 8'h00, 8'h00};
    m_en = 1;
    repeat (3) @(posedge clk);
    // R1: values while reset is held
    @(negedge clk);
    peek("R1");
    rst_n = 1'b1;
    cyc(0, 0, 0, 2'd0, 8'h00, 8'h00, "R1");

    // R6: direct writes to all entries
    cyc(0, 0, 1, 2'd0, 8'h05, 8'h00, "R6");
    cyc(0, 0, 1, 2'd1, 8'h11, 8'h00, "R6");
    cyc(0, 0, 1, 2'd2, 8'h22, 8'h00, "R6");
    peek("R6");

    // R2: two nested interrupts
    cyc(1, 0, 0, 2'd0, 8'h00, 8'h0C, "R2");
    peek("R2");
    check("R2 first push", page_o, 8'h0C);
    cyc(1, 0, 0, 2'd0, 8'h00, 8'h3A, "R2");
    peek("R2");
    check("R2 nested push", page_o, 8'h3A);

    // R3: unwind both levels
    cyc(0, 1, 0, 2'd0, 8'h00, 8'h00, "R3");
    peek("R3");
    check("R3 first return", page_o, 8'h0C);
    cyc(0, 1, 0, 2'd0, 8'h00, 8'h00, "R3");
    peek("R3");
    check("R3 second return", page_o, 8'h05);

    // R4: idle cycles with a moving select and unused data
    for (int k = 0; k < 4; k++)
      cyc(0, 0, 0, 2'(k), 8'hA5, 8'h77, "R4");
    peek("R4");

    // R11: retarget the saved page during an interrupt
    cyc(0, 0, 1, 2'd0, 8'h01, 8'h00, "R11");
    cyc(1, 0, 0, 2'd0, 8'h00, 8'h0C, "R11");
    cyc(0, 0, 1, 2'd1, 8'h07, 8'h00, "R11");
    cyc(0, 1, 0, 2'd0, 8'h00, 8'h00, "R11");
    check("R11 return to modified page", page_o, 8'h07);

    // R7: write coinciding with push, then with pop
    cyc(1, 0, 1, 2'd0, 8'hFF, 8'h20, "R7");
    check("R7 push wins", page_o, 8'h20);
    cyc(0, 1, 1, 2'd1, 8'hEE, 8'h00, "R7");
    peek("R7");

    // R10: both strobes in the same cycle
    cyc(1, 1, 0, 2'd0, 8'h00, 8'h44, "R10");
    check("R10 entry wins", page_o, 8'h44);
    peek("R10");

    // R9 / R8: disable automatic mode; strobes ignored, writes still work
    cyc(0, 0, 1, 2'd3, 8'hFE, 8'h00, "R9");
    check("R9 enable cleared", {7'd0, auto_en_o}, 8'h00);
    cyc(1, 0, 0, 2'd0, 8'h00, 8'h55, "R8");
    cyc(0, 1, 0, 2'd0, 8'h00, 8'h00, "R8");
    cyc(1, 1, 0, 2'd0, 8'h00, 8'h66, "R8");
    peek("R8");
    cyc(0, 0, 1, 2'd2, 8'h9C, 8'h00, "R6");
    peek("R6");

    // R9: re-enable with a push in the same cycle (old enable decides)
    cyc(1, 0, 1, 2'd3, 8'h01, 8'h70, "R9");
    peek("R9");
    cyc(1, 0, 0, 2'd0, 8'h00, 8'h71, "R9");
    check("R9 push after re-enable", page_o, 8'h71);
    peek("R9");
    // control write to clear during a pop: pop still happens
    cyc(0, 1, 1, 2'd3, 8'h00, 8'h00, "R9");
    peek("R9");
    cyc(0, 0, 1, 2'd3, 8'h01, 8'h00, "R9");
    peek("R9");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule